// File: doc/BRIEF.md
# Dual-Mode Serial Receiver

This block receives serial characters in one of three ways: asynchronously, with start and stop bits and 16x oversampling; synchronously as clock master, generating the bit clock itself; or synchronously as clock slave, following an external bit clock. A single byte-wide control/status register configures it and reports on it. Software sets the port enable, the character width and the receive enables there. It reads back the error flags and the ninth data bit of the oldest buffered character from the same register. Completed characters queue in a two-entry buffer and are drained one at a time with a read strobe.

The bit-rate reference is an external `sample_tick`. In asynchronous mode the tick runs at sixteen times the bit rate. In synchronous master mode each tick advances the generated clock by half a period. The choice between synchronous and asynchronous, and between master and slave, arrives on two static configuration inputs. The block reports whether it owns the pins and whether it drives the clock line.

Top module: `serrx_top`

## Requirements
- R1: After reset the status byte reads 0x00, `rd_valid` is 0, `ck_oe` is 0, `ck_out` is 0 and `pins_serial` is 0.
- R2: Status bit 7 (port enable) gates the whole receiver. While it is 0, `pins_serial` and `ck_oe` are 0, `ck_out` stays 0 and no character is received. While it is 1, `pins_serial` is 1.
- R3: Bits 7 (port enable), 6 (nine-bit select), 5 (single-shot enable) and 4 (continuous enable) are written by `ctl_wr` with `ctl_wdata` and read back on `ctl_rdata`. Bit 3 always reads 0.
- R4: In asynchronous mode (`cfg_sync`=0) with bits 7 and 4 set, a falling edge on `dt_in` starts a character. Each bit lasts 16 ticks and is sampled at its middle. Data arrives LSB first and is followed by one stop bit. The character is then buffered.
- R5: With bit 6 set, nine data bits are received, and status bit 0 shows the ninth bit of the oldest buffered character. With bit 6 clear, bit 0 reads 0.
- R6: A stop bit sampled as 0 marks its character with a framing error. Status bit 2 shows the mark of the oldest buffered character, so the flag changes when a read advances the buffer.
- R7: Up to two characters are held. `rd_valid` and `rd_data` present the oldest one, and a cycle with `rd_strobe` high removes it.
- R8: If a character completes while both entries are full, status bit 1 (overrun) is set and that character is discarded. While bit 1 is set, no new character starts. The flag survives buffer reads and writes that keep bit 4 set.
- R9: Only a register write with bit 4 equal to 0 clears status bit 1.
- R10: In synchronous master mode (`cfg_sync`=1, `cfg_master`=1), `ck_oe` is 1 while the port is enabled. Each tick toggles `ck_out`, and `dt_in` is sampled just before each falling edge. With only bit 5 set, exactly one character is received, the hardware then clears bit 5 and the clock stops.
- R11: In synchronous master mode with bit 4 set, reception continues character after character and bit 5 is left as written.
- R12: In synchronous slave mode (`cfg_sync`=1, `cfg_master`=0), bits are sampled on rising edges of `ck_in`, `ck_oe` is 0, bit 5 has no effect and only bit 4 enables reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Bit-rate reference strobe |
| cfg_sync | input | 1 | 1 = synchronous mode, 0 = asynchronous |
| cfg_master | input | 1 | In synchronous mode, 1 = block generates the clock |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control/status read value |
| rd_strobe | input | 1 | Removes the oldest buffered character |
| rd_valid | output | 1 | A character is buffered |
| rd_data | output | 8 | Low eight bits of the oldest character |
| dt_in | input | 1 | Serial data line |
| ck_in | input | 1 | Serial clock line, slave mode |
| ck_out | output | 1 | Generated serial clock, master mode |
| ck_oe | output | 1 | Drive enable for the clock line |
| pins_serial | output | 1 | Data and clock pins are owned by the serial port |

## Verification
The hardest state to reach is an overrun that persists. To get there, three asynchronous characters are sent back to back without any read. Both buffered characters are then drained, the register is rewritten with the continuous enable still set, and a fourth character is sent to show that reception stays blocked. Synchronous master mode is harder to drive because the bench must follow the clock the block generates. It does this by presenting each next data bit just after every falling edge of `ck_out`, and it counts clock edges after a single-shot character to confirm that the clock stops.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

  typedef enum logic [1:0] {
    MODE_ASYNC   = 2'd0,
    MODE_SMASTER = 2'd1,
    MODE_SSLAVE  = 2'd2
  } rx_mode_e;

  typedef struct packed {
    logic       ferr;
    logic       bit8;
    logic [7:0] data;
  } rx_char_t;

  localparam int CS_PORT_EN = 7;
  localparam int CS_NINE    = 6;
  localparam int CS_ONE     = 5;
  localparam int CS_CONT    = 4;
  localparam int CS_FERR    = 2;
  localparam int CS_OERR    = 1;
  localparam int CS_BIT8    = 0;

endpackage

// File: rtl/serrx_sync.sv
module serrx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
    if (do_pop)  rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
    if (do_push && !do_pop)      cnt_d = cnt_q + CW'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assign dout = mem[rd_q];
endmodule

// File: rtl/serrx_engine.sv
module serrx_engine
  import serrx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  rx_mode_e   mode,
  input  logic       en,
  input  logic       inhibit,
  input  logic       nine,
  input  logic       dt_s,
  input  logic       ck_rise,
  output logic       done,
  output logic [8:0] word,
  output logic       ferr,
  output logic       ck_out
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} st_e;

  st_e           state_q, state_d;
  logic [CW-1:0] tcnt_q, tcnt_d;
  logic [3:0]    idx_q, idx_d;
  logic [8:0]    word_q, word_d;
  logic          ck_q, ck_d, ferr_q, ferr_d, done_q, done_d, dt_prev_q;
  logic          last_bit;

  assign last_bit = (idx_q == (nine ? 4'd8 : 4'd7));

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    idx_d   = idx_q;
    word_d  = word_q;
    ck_d    = ck_q;
    ferr_d  = ferr_q;
    done_d  = 1'b0;
    if (!en) begin
      state_d = ST_IDLE;
      ck_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (!inhibit) begin
            tcnt_d = '0;
            idx_d  = '0;
            word_d = '0;
            ck_d   = 1'b0;
            if (mode == MODE_ASYNC) begin
              if (dt_prev_q && !dt_s) state_d = ST_START;
            end else begin
              state_d = ST_DATA;
            end
          end
        end
        ST_START: begin
          if (tick) begin
            if (tcnt_q == CW'(HALF - 1)) begin
              tcnt_d  = '0;
              state_d = dt_s ? ST_IDLE : ST_DATA;
            end else begin
              tcnt_d = tcnt_q + CW'(1);
            end
          end
        end
        ST_DATA: begin
          if (mode == MODE_ASYNC) begin
            if (tick) begin
              if (tcnt_q == CW'(OVS - 1)) begin
                tcnt_d        = '0;
                word_d[idx_q] = dt_s;
                if (last_bit) state_d = ST_STOP;
                else          idx_d   = idx_q + 4'd1;
              end else begin
                tcnt_d = tcnt_q + CW'(1);
              end
            end
          end else if (mode == MODE_SMASTER) begin
            if (tick) begin
              if (!ck_q) begin
                ck_d = 1'b1;
              end else begin
                ck_d          = 1'b0;
                word_d[idx_q] = dt_s;
                if (last_bit) begin
                  done_d  = 1'b1;
                  ferr_d  = 1'b0;
                  state_d = ST_IDLE;
                end else begin
                  idx_d = idx_q + 4'd1;
                end
              end
            end
          end else begin
            if (ck_rise) begin
              word_d[idx_q] = dt_s;
              if (last_bit) begin
                done_d  = 1'b1;
                ferr_d  = 1'b0;
                state_d = ST_IDLE;
              end else begin
                idx_d = idx_q + 4'd1;
              end
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (tcnt_q == CW'(OVS - 1)) begin
              done_d  = 1'b1;
              ferr_d  = !dt_s;
              state_d = ST_IDLE;
            end else begin
              tcnt_d = tcnt_q + CW'(1);
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      tcnt_q    <= '0;
      idx_q     <= '0;
      word_q    <= '0;
      ck_q      <= 1'b0;
      ferr_q    <= 1'b0;
      done_q    <= 1'b0;
      dt_prev_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      tcnt_q    <= tcnt_d;
      idx_q     <= idx_d;
      word_q    <= word_d;
      ck_q      <= ck_d;
      ferr_q    <= ferr_d;
      done_q    <= done_d;
      dt_prev_q <= dt_s;
    end
  end

  assign done   = done_q;
  assign word   = word_q;
  assign ferr   = ferr_q;
  assign ck_out = ck_q;
endmodule

// File: rtl/serrx_top.sv
module serrx_top
  import serrx_pkg::*;
#(
  parameter int OVS        = 16,
  parameter int BUF_DEPTH  = 2,
  parameter int SYNC_STAGE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       cfg_sync,
  input  logic       cfg_master,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       rd_strobe,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  input  logic       dt_in,
  input  logic       ck_in,
  output logic       ck_out,
  output logic       ck_oe,
  output logic       pins_serial
);
  localparam int CHAR_W = $bits(rx_char_t);

  logic     port_en_q, port_en_d, nine_q, nine_d, one_q, one_d;
  logic     cont_q, cont_d, oerr_q, oerr_d;
  rx_mode_e mode;
  logic     rx_en, dt_s, ck_s, ck_prev_q, ck_rise;
  logic     char_done, eng_ferr, eng_ck;
  logic [8:0] eng_word;
  logic     buf_push, buf_pop, buf_empty, buf_full, ovf;
  rx_char_t buf_din, head;
  logic     unused_wbits;

  assign unused_wbits = ^ctl_wdata[3:0];

  assign mode = !cfg_sync ? MODE_ASYNC : (cfg_master ? MODE_SMASTER : MODE_SSLAVE);
  assign rx_en = port_en_q && ((mode == MODE_SMASTER) ? (cont_q || one_q) : cont_q);

  serrx_sync #(.STAGES(SYNC_STAGE), .RST_VAL(1'b1)) u_dt_sync (
    .clk(clk), .rst_n(rst_n), .d(dt_in), .q(dt_s));
  serrx_sync #(.STAGES(SYNC_STAGE), .RST_VAL(1'b0)) u_ck_sync (
    .clk(clk), .rst_n(rst_n), .d(ck_in), .q(ck_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_prev_q <= 1'b0;
    else        ck_prev_q <= ck_s;
  end
  assign ck_rise = ck_s && !ck_prev_q;

  serrx_engine #(.OVS(OVS)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .mode(mode), .en(rx_en),
    .inhibit(oerr_q), .nine(nine_q), .dt_s(dt_s), .ck_rise(ck_rise),
    .done(char_done), .word(eng_word), .ferr(eng_ferr), .ck_out(eng_ck));

  assign ovf      = char_done && buf_full && !oerr_q;
  assign buf_push = char_done && !buf_full && !oerr_q;
  assign buf_pop  = rd_strobe && !buf_empty;
  assign buf_din  = '{ferr: eng_ferr, bit8: nine_q & eng_word[8], data: eng_word[7:0]};

  serrx_fifo #(.DEPTH(BUF_DEPTH), .W(CHAR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(buf_push), .din(buf_din), .pop(buf_pop),
    .dout(head), .empty(buf_empty), .full(buf_full));

  always_comb begin
    port_en_d = port_en_q;
    nine_d    = nine_q;
    one_d     = one_q;
    cont_d    = cont_q;
    oerr_d    = oerr_q;
    if (ovf) oerr_d = 1'b1;
    if (char_done && (mode == MODE_SMASTER) && !cont_q) one_d = 1'b0;
    if (ctl_wr) begin
      port_en_d = ctl_wdata[CS_PORT_EN];
      nine_d    = ctl_wdata[CS_NINE];
      one_d     = ctl_wdata[CS_ONE];
      cont_d    = ctl_wdata[CS_CONT];
      if (!ctl_wdata[CS_CONT]) oerr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_en_q <= 1'b0;
      nine_q    <= 1'b0;
      one_q     <= 1'b0;
      cont_q    <= 1'b0;
      oerr_q    <= 1'b0;
    end else begin
      port_en_q <= port_en_d;
      nine_q    <= nine_d;
      one_q     <= one_d;
      cont_q    <= cont_d;
      oerr_q    <= oerr_d;
    end
  end

  always_comb begin
    ctl_rdata             = '0;
    ctl_rdata[CS_PORT_EN] = port_en_q;
    ctl_rdata[CS_NINE]    = nine_q;
    ctl_rdata[CS_ONE]     = one_q;
    ctl_rdata[CS_CONT]    = cont_q;
    ctl_rdata[CS_FERR]    = !buf_empty && head.ferr;
    ctl_rdata[CS_OERR]    = oerr_q;
    ctl_rdata[CS_BIT8]    = !buf_empty && head.bit8;
  end

  assign rd_valid    = !buf_empty;
  assign rd_data     = buf_empty ? 8'h00 : head.data;
  assign pins_serial = port_en_q;
  assign ck_oe       = port_en_q && (mode == MODE_SMASTER);
  assign ck_out      = eng_ck && ck_oe;
endmodule

// File: rtl/serrx_chk.sv
module serrx_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_wr,
  input logic wr_cont,
  input logic st_one,
  input logic st_ferr,
  input logic st_oerr,
  input logic st_bit8,
  input logic rd_valid,
  input logic rd_strobe,
  input logic ck_oe,
  input logic ck_out,
  input logic char_done
);
  AST_OERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st_oerr && !(ctl_wr && !wr_cont) |=> st_oerr); // R8

  AST_OERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !wr_cont |=> !st_oerr); // R9

  AST_ONE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_one) |-> ($past(ctl_wr) || $past(char_done))); // R10

  AST_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_oe |-> !ck_out); // R2

  AST_HEAD_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && $past(rd_valid) && !$past(rd_strobe) |-> ($stable(st_ferr) && $stable(st_bit8))); // R6
endmodule

bind serrx_top serrx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_cont(ctl_wdata[4]),
  .st_one(ctl_rdata[5]), .st_ferr(ctl_rdata[2]), .st_oerr(ctl_rdata[1]),
  .st_bit8(ctl_rdata[0]), .rd_valid(rd_valid), .rd_strobe(rd_strobe),
  .ck_oe(ck_oe), .ck_out(ck_out), .char_done(char_done));

// File: tb/tb_serrx_top.sv
module tb_serrx_top;
  logic       clk = 1'b0;
  logic       rst_n, sample_tick, cfg_sync, cfg_master, ctl_wr, rd_strobe;
  logic       dt_in, ck_in;
  logic [7:0] ctl_wdata, ctl_rdata, rd_data;
  logic       rd_valid, ck_out, ck_oe, pins_serial;

  int total = 0;
  int bad   = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  bit m_en = 0, m_nine = 0, m_cont = 0;
  logic [9:0] expq[$];

  always #5 clk = ~clk;

  serrx_top dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .cfg_sync(cfg_sync),
    .cfg_master(cfg_master), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rd_strobe(rd_strobe), .rd_valid(rd_valid),
    .rd_data(rd_data), .dt_in(dt_in), .ck_in(ck_in), .ck_out(ck_out),
    .ck_oe(ck_oe), .pins_serial(pins_serial));

  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1) % tick_div;
    sample_tick = (tick_cnt == 0);
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock comparison of the register fields against the behavioural model (R2, R3)
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #3;
      chk("R3 bit7", ctl_rdata[7], m_en);
      chk("R3 bit6", ctl_rdata[6], m_nine);
      chk("R3 bit4", ctl_rdata[4], m_cont);
      chk("R3 bit3", ctl_rdata[3], 0);
      chk("R2 pins", pins_serial, m_en);
      chk("R2 ck_oe", ck_oe, m_en && cfg_sync && cfg_master);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = v;
    m_en = v[7];
    m_nine = v[6];
    m_cont = v[4];
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic async_send(input logic [8:0] v, input int n, input logic stopb);
    @(negedge clk);
    dt_in = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      dt_in = v[i];
      repeat (16) @(negedge clk);
    end
    dt_in = stopb;
    repeat (16) @(negedge clk);
    dt_in = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic master_serve(input logic [7:0] v);
    dt_in = v[0];
    for (int i = 1; i < 8; i++) begin
      @(negedge ck_out);
      #1 dt_in = v[i];
    end
    @(negedge ck_out);
    #1;
    @(negedge clk);
  endtask

  task automatic slave_send(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ck_in = 1'b0;
      dt_in = v[i];
      repeat (6) @(negedge clk);
      ck_in = 1'b1;
      repeat (6) @(negedge clk);
    end
    ck_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic read_chk(input string req);
    logic [9:0] e;
    if (expq.size() == 0) begin
      chk({req, " model empty"}, 1, 0);
      return;
    end
    e = expq.pop_front();
    @(negedge clk);
    chk({req, " valid"}, rd_valid, 1);
    chk({req, " data"}, rd_data, e[7:0]);
    chk({req, " ferr/bit8"}, {ctl_rdata[2], ctl_rdata[0]}, e[9:8]);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  initial begin
    int highs;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = 8'h00; rd_strobe = 1'b0;
    dt_in = 1'b1; ck_in = 1'b0; cfg_sync = 1'b0; cfg_master = 1'b0; sample_tick = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", ctl_rdata, 8'h00);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 ck_oe", ck_oe, 0);
    chk("R1 ck_out", ck_out, 0);
    chk("R1 pins", pins_serial, 0);

    // R2 port disabled: continuous enable alone receives nothing
    wr(8'h10);
    async_send(9'h033, 8, 1'b1);
    chk("R2 no rx when disabled", rd_valid, 0);
    chk("R2 pins off", pins_serial, 0);

    // R3 register read-back, bit 3 stays 0
    wr(8'h98);
    chk("R3 readback", ctl_rdata, 8'h90);
    chk("R2 pins on", pins_serial, 1);

    // R4/R6/R7 async characters, one with a bad stop bit
    async_send(9'h0A5, 8, 1'b1); expq.push_back({1'b0, 1'b0, 8'hA5});
    chk("R4 char arrived", rd_valid, 1);
    async_send(9'h03C, 8, 1'b0); expq.push_back({1'b1, 1'b0, 8'h3C});
    chk("R6 ferr shows head only", ctl_rdata[2], 0);
    read_chk("R7 first");
    read_chk("R6 ferr after read");
    chk("R7 drained", rd_valid, 0);

    // R8/R9 overrun
    async_send(9'h011, 8, 1'b1); expq.push_back({2'b00, 8'h11});
    async_send(9'h022, 8, 1'b1); expq.push_back({2'b00, 8'h22});
    async_send(9'h033, 8, 1'b1);
    chk("R8 overrun set", ctl_rdata[1], 1);
    read_chk("R8 kept first");
    read_chk("R8 kept second");
    chk("R8 third discarded", rd_valid, 0);
    chk("R8 flag after reads", ctl_rdata[1], 1);
    wr(8'h90);
    chk("R9 rewrite with cont keeps flag", ctl_rdata[1], 1);
    async_send(9'h044, 8, 1'b1);
    chk("R8 reception inhibited", rd_valid, 0);
    wr(8'h80);
    chk("R9 cleared by cont=0", ctl_rdata[1], 0);
    wr(8'h90);
    async_send(9'h055, 8, 1'b1); expq.push_back({2'b00, 8'h55});
    read_chk("R9 receive resumes");

    // R5 nine-bit characters
    wr(8'hD0);
    async_send(9'h1C3, 9, 1'b1); expq.push_back({1'b0, 1'b1, 8'hC3});
    async_send(9'h07E, 9, 1'b1); expq.push_back({1'b0, 1'b0, 8'h7E});
    read_chk("R5 ninth bit 1");
    read_chk("R5 ninth bit 0");

    // R10 sync master single shot
    wr(8'h00);
    cfg_sync = 1'b1; cfg_master = 1'b1; tick_div = 4;
    dt_in = 1'b0;
    wr(8'hA0);
    chk("R10 ck_oe", ck_oe, 1);
    master_serve(8'h5A); expq.push_back({2'b00, 8'h5A});
    repeat (4) @(negedge clk);
    chk("R10 single-shot cleared", ctl_rdata[5], 0);
    highs = 0;
    repeat (60) begin @(negedge clk); if (ck_out) highs++; end
    chk("R10 clock stopped", highs, 0);
    read_chk("R10 byte");

    // R11 continuous overrides single shot
    wr(8'hB0);
    master_serve(8'h81); expq.push_back({2'b00, 8'h81});
    master_serve(8'h6E); expq.push_back({2'b00, 8'h6E});
    chk("R11 single-shot untouched", ctl_rdata[5], 1);
    wr(8'h80);
    read_chk("R11 byte one");
    read_chk("R11 byte two");

    // R12 sync slave
    wr(8'h00);
    cfg_master = 1'b0;
    wr(8'hA0);
    chk("R12 no clock drive", ck_oe, 0);
    slave_send(8'h99);
    chk("R12 single-shot ignored", rd_valid, 0);
    wr(8'h90);
    slave_send(8'hC6); expq.push_back({2'b00, 8'hC6});
    read_chk("R12 slave byte");

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule